// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block sends words on a single serial line, least significant bit first. Each frame is a low start bit, then eight data bits or nine, then one or two high stop bits. Bit timing comes from a one-cycle baud strobe supplied from outside, and one bit lasts exactly one strobe interval. The line rests high.

A one-word holding stage sits in front of the shifter. A word written while the shifter is empty goes straight into the shifter, and the holding stage stays free. A word written during a frame waits in the holding stage and follows the current frame with no gap. Two flags report the state of the block. The empty flag means another word may be written. The idle flag means the line has gone quiet after a frame. Both flags clear only when a status read is followed by an accepted write. A request input turns the next frame slot into break characters. Each break character holds the line low for 14 bit times. Break characters repeat while the request stays high and end with ordinary stop bits.

The write side is a valid/ready port, and ready is the empty flag. A word offered while ready is low is dropped, not stalled. The writer must keep valid high until it sees ready, or it loses the word.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset the line `tx` is 1, `txe` is 1, `tidle` is 1 and `wr_ready` is 1.
- R2: A frame is a 0 start bit, then the data bits LSB first, then stop bits of value 1. There are 8 data bits when `nine_bit`=0. There are 9 data bits when `nine_bit`=1, and `wr_data[8]` is the last data bit. There is one stop bit when `two_stop`=0 and two when `two_stop`=1. `tx` changes only in the cycle after a clock edge at which `baud_tick` was 1, and each bit lasts one tick interval.
- R3: A write accepted while the shifter is empty and `brk_req` is 0 loads the shifter directly. The start bit goes out at the next tick, and `txe` is still 1 in the cycle after the write.
- R4: A write accepted during a frame is held. It is sent immediately after the current frame with no idle bit between the two frames. `txe` returns to 1 when the held word moves into the shifter.
- R5: `wr_ready` equals `txe`. A write offered while `wr_ready` is 0 is ignored, and that word is never transmitted.
- R6: `txe` and `tidle` fall only on an accepted write that was preceded by a `stat_rd` pulse with no accepted write between the pulse and that write. An accepted write without such a pulse leaves both flags unchanged.
- R7: `tidle` rises only when the transmitter runs out of work at the end of a frame or at the end of the stop bits after a break. While break characters are being sent, `tidle` stays 0.
- R8: With `brk_req`=1 at a frame boundary, the line goes low for 14 bit times (one start bit and 13 zero bits). This repeats for every boundary at which `brk_req` is still 1. After the last break character, the number of stop bits selected by `two_stop` follows.
- R9: Break characters never change `txe`, so they never raise or drop `irq`.
- R10: `irq` is 1 exactly when `txe` is 1 and `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe for a data word |
| wr_ready | output | 1 | High when a write will be accepted |
| wr_data | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| stat_rd | input | 1 | Status-read pulse that allows the next accepted write to clear the flags |
| brk_req | input | 1 | Request for break characters |
| nine_bit | input | 1 | 1 selects 9 data bits |
| two_stop | input | 1 | 1 selects two stop bits |
| int_en | input | 1 | Transmit interrupt enable |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| tx | output | 1 | Serial line |
| txe | output | 1 | Transmit-empty flag |
| tidle | output | 1 | Transmitter-idle flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The flags and `wr_ready` are registered, so they settle one cycle after the edge that accepts a write. The bench reads them at the falling edge that follows that edge, and `irq` follows `txe` in the same cycle. The serial line moves one cycle after each tick, so the bench records `tx` at the falling edge after every tick edge and decodes frames and break runs from that bit log. The decode runs only after waiting longer than the longest frame, or after observing the zero run the break test needs.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    FR_DATA = 2'd0,
    FR_BRK  = 2'd1,
    FR_TAIL = 2'd2
  } fr_kind_t;
endpackage

// File: rtl/stx_frame.sv
// Turns a word plus mode selects into an LSB-first bit image and its length.
module stx_frame #(
  parameter int BASE_W = 8,
  parameter int SH_W   = 14,
  parameter int CNT_W  = 4
) (
  input  logic [BASE_W:0]  word,
  input  logic             nine,
  input  logic             two,
  output logic [SH_W-1:0]  frame,
  output logic [CNT_W-1:0] len
);
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < BASE_W; i++) frame[i+1] = word[i];
    if (nine) frame[BASE_W+1] = word[BASE_W];
    len = CNT_W'(BASE_W + 2) + CNT_W'(nine) + CNT_W'(two);
  end
endmodule

// File: rtl/stx_flags.sv
// Holding stage, empty/idle flags and the read-then-write clear arming.
module stx_flags #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              take,
  input  logic              went_idle,
  output logic              txe,
  output logic              tidle,
  output logic              src_valid,
  output logic [WORD_W-1:0] src_word
);
  logic              arm_q, hold_v, txe_q, tidle_q;
  logic [WORD_W-1:0] hold_q;
  logic              acc, direct, to_hold;

  assign acc       = wr_valid & txe_q;
  assign src_valid = hold_v | acc;
  assign src_word  = hold_v ? hold_q : wr_data;
  assign direct    = take & ~hold_v;
  assign to_hold   = acc & ~direct;
  assign txe       = txe_q;
  assign tidle     = tidle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      hold_v  <= 1'b0;
      hold_q  <= '0;
      txe_q   <= 1'b1;
      tidle_q <= 1'b1;
    end else begin
      if (stat_rd)  arm_q <= 1'b1;
      else if (acc) arm_q <= 1'b0;

      if (to_hold) begin
        hold_v <= 1'b1;
        hold_q <= wr_data;
      end else if (take) begin
        hold_v <= 1'b0;
      end

      if (acc && arm_q)         txe_q <= ~to_hold;
      else if (take && hold_v)  txe_q <= 1'b1;

      if (acc && arm_q)         tidle_q <= 1'b0;
      else if (went_idle)       tidle_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stx_shift.sv
// Bit shifter: data frames, break characters and the stop tail after a break.
module stx_shift
  import stx_pkg::*;
#(
  parameter int SH_W    = 14,
  parameter int CNT_W   = 4,
  parameter int BRK_LEN = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             brk_req,
  input  logic             two_stop,
  input  logic             src_valid,
  input  logic [SH_W-1:0]  src_frame,
  input  logic [CNT_W-1:0] src_len,
  output logic             take,
  output logic             went_idle,
  output logic             tx
);
  logic             busy, tx_q;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] left;
  fr_kind_t         kind;
  logic             end_now, cur_brk;
  logic [SH_W-1:0]  nf;
  logic [CNT_W-1:0] nlen;
  fr_kind_t         nk;

  assign end_now   = busy & tick & (left == '0);
  assign cur_brk   = (kind == FR_BRK);
  assign take      = (~busy & src_valid & ~brk_req) |
                     (end_now & ~cur_brk & ~brk_req & src_valid);
  assign went_idle = end_now & ~cur_brk & ~brk_req & ~src_valid;
  assign tx        = tx_q;

  always_comb begin
    nf   = src_frame;
    nlen = src_len;
    nk   = FR_DATA;
    if (brk_req) begin
      nf   = '0;
      nlen = CNT_W'(BRK_LEN);
      nk   = FR_BRK;
    end else if (cur_brk) begin
      nf   = '1;
      nlen = CNT_W'(1) + CNT_W'(two_stop);
      nk   = FR_TAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tx_q <= 1'b1;
      sh   <= '1;
      left <= '0;
      kind <= FR_DATA;
    end else if (!busy) begin
      if (tick && brk_req) begin
        busy <= 1'b1;
        kind <= FR_BRK;
        tx_q <= 1'b0;
        sh   <= '0;
        left <= CNT_W'(BRK_LEN - 1);
      end else if (src_valid && !brk_req) begin
        busy <= 1'b1;
        kind <= FR_DATA;
        sh   <= src_frame;
        left <= src_len;
      end
    end else if (tick) begin
      if (left != '0) begin
        tx_q <= sh[0];
        sh   <= sh >> 1;
        left <= left - CNT_W'(1);
      end else if (went_idle) begin
        busy <= 1'b0;
        tx_q <= 1'b1;
      end else begin
        tx_q <= nf[0];
        sh   <= nf >> 1;
        left <= nlen - CNT_W'(1);
        kind <= nk;
      end
    end
  end
endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk #(
  parameter int BASE_W    = 8,
  parameter int BRK_ZEROS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BASE_W:0]   wr_data,
  input  logic              stat_rd,
  input  logic              brk_req,
  input  logic              nine_bit,
  input  logic              two_stop,
  input  logic              int_en,
  input  logic              baud_tick,
  output logic              tx,
  output logic              txe,
  output logic              tidle,
  output logic              irq
);
  localparam int WORD_W  = BASE_W + 1;
  localparam int DATA_FR = BASE_W + 4;
  localparam int BRK_LEN = BRK_ZEROS + 1;
  localparam int SH_W    = (DATA_FR > BRK_LEN) ? DATA_FR : BRK_LEN;
  localparam int CNT_W   = $clog2(SH_W + 1);

  logic              take, went_idle, src_valid, txe_w;
  logic [WORD_W-1:0] src_word;
  logic [SH_W-1:0]   src_frame;
  logic [CNT_W-1:0]  src_len;

  stx_flags #(.WORD_W(WORD_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .stat_rd(stat_rd), .take(take), .went_idle(went_idle),
    .txe(txe_w), .tidle(tidle), .src_valid(src_valid), .src_word(src_word)
  );

  stx_frame #(.BASE_W(BASE_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_frame (
    .word(src_word), .nine(nine_bit), .two(two_stop),
    .frame(src_frame), .len(src_len)
  );

  stx_shift #(.SH_W(SH_W), .CNT_W(CNT_W), .BRK_LEN(BRK_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .brk_req(brk_req),
    .two_stop(two_stop), .src_valid(src_valid), .src_frame(src_frame),
    .src_len(src_len), .take(take), .went_idle(went_idle), .tx(tx)
  );

  assign txe      = txe_w;
  assign wr_ready = txe_w;
  assign irq      = txe_w & int_en;
endmodule

// File: rtl/serial_tx_brk_chk.sv
module serial_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic baud_tick,
  input logic tx,
  input logic txe,
  input logic tidle,
  input logic irq
);
  assert_txe_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txe) |-> $past(wr_valid && wr_ready));

  assert_tidle_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tidle) |-> $past(wr_valid && wr_ready));

  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx) |-> $past(baud_tick));

  assert_idle_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tidle) |-> $past(baud_tick));

  assert_irq_needs_txe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> txe);
endmodule

bind serial_tx_brk serial_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .baud_tick(baud_tick), .tx(tx), .txe(txe), .tidle(tidle), .irq(irq)
);

// File: tb/sim_serial_tx_brk.sv
`timescale 1ns/1ps
module sim_serial_tx_brk;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, stat_rd = 1'b0, brk_req = 1'b0;
  logic nine_bit = 1'b0, two_stop = 1'b0, int_en = 1'b0, baud_tick = 1'b0;
  logic [8:0] wr_data = '0;
  logic wr_ready, tx, txe, tidle, irq;

  int total = 0, bad = 0, cyc = 0, tcnt = 0, lidx = 0, zrun = 0;
  logic line_log [0:4095];

  always #2.5 clk = ~clk;

  serial_tx_brk u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .stat_rd(stat_rd), .brk_req(brk_req),
    .nine_bit(nine_bit), .two_stop(two_stop), .int_en(int_en),
    .baud_tick(baud_tick), .tx(tx), .txe(txe), .tidle(tidle), .irq(irq)
  );

  // Tick every 4 cycles; record the line after each tick edge.
  always @(negedge clk) begin
    if (baud_tick && lidx < 4096) begin
      line_log[lidx] = tx;
      lidx = lidx + 1;
      zrun = tx ? 0 : zrun + 1;
    end
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 0);
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc >= 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog all requirements act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  function automatic void exp_frame(input logic [8:0] d, input logic nb,
                                    input logic ts, output logic [13:0] b,
                                    output int n);
    b = '1; b[0] = 1'b0; n = 1;
    for (int i = 0; i < 8; i++) begin b[n] = d[i]; n++; end
    if (nb) begin b[n] = d[8]; n++; end
    n = n + (ts ? 2 : 1);
  endfunction

  task automatic chk_frame(input int from, input bit strict, input logic [8:0] d,
                           input logic nb, input logic ts, input string req,
                           output int nxt);
    logic [13:0] eb, got;
    int n, p;
    p = from;
    exp_frame(d, nb, ts, eb, n);
    if (!strict) while (p < lidx && line_log[p]) p++;
    got = '1;
    for (int i = 0; i < n; i++)
      got[i] = (p + i < lidx) ? line_log[p + i] : ~eb[i];
    check(req, "frame bits", {18'd0, got}, {18'd0, eb});
    nxt = p + n;
  endtask

  initial begin
    int s, nx, z;
    logic [8:0] rd;
    void'($urandom(32'd4242));
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "tx", {31'd0, tx}, 32'd1);
    check("R1", "txe", {31'd0, txe}, 32'd1);
    check("R1", "tidle", {31'd0, tidle}, 32'd1);
    check("R5", "wr_ready", {31'd0, wr_ready}, 32'd1);
    check("R10", "irq off", {31'd0, irq}, 32'd0);
    int_en = 1'b1;
    @(negedge clk);
    check("R10", "irq on", {31'd0, irq}, 32'd1);

    // R3/R6: armed write while empty
    s = lidx;
    do_read();
    do_write(9'h0A5);
    check("R3", "txe after direct load", {31'd0, txe}, 32'd1);
    check("R6", "tidle cleared", {31'd0, tidle}, 32'd0);
    cycles(80);
    chk_frame(s, 0, 9'h0A5, 1'b0, 1'b0, "R2", nx);
    check("R7", "tidle after frame", {31'd0, tidle}, 32'd1);

    // R2: nine bits, two stops
    nine_bit = 1'b1; two_stop = 1'b1;
    s = lidx;
    do_read();
    do_write(9'h1C3);
    cycles(80);
    chk_frame(s, 0, 9'h1C3, 1'b1, 1'b1, "R2", nx);
    nine_bit = 1'b0; two_stop = 1'b0;

    // R6: write without status read keeps flags
    s = lidx;
    do_write(9'h03C);
    check("R6", "tidle kept", {31'd0, tidle}, 32'd1);
    check("R6", "txe kept", {31'd0, txe}, 32'd1);
    cycles(80);
    chk_frame(s, 0, 9'h03C, 1'b0, 1'b0, "R2", nx);

    // R4/R5: holding stage and ignored write
    s = lidx;
    do_read();
    do_write(9'h011);
    do_read();
    do_write(9'h0E7);
    check("R4", "txe with word held", {31'd0, txe}, 32'd0);
    check("R5", "ready low", {31'd0, wr_ready}, 32'd0);
    check("R10", "irq low", {31'd0, irq}, 32'd0);
    do_write(9'h055);
    while (!txe) @(negedge clk);
    check("R10", "irq back", {31'd0, irq}, 32'd1);
    cycles(100);
    chk_frame(s, 0, 9'h011, 1'b0, 1'b0, "R4", nx);
    chk_frame(nx, 1, 9'h0E7, 1'b0, 1'b0, "R4", nx);
    z = 0;
    for (int i = nx; i < lidx; i++) if (!line_log[i]) z++;
    check("R5", "ignored word absent", z, 32'd0);
    check("R7", "tidle after pair", {31'd0, tidle}, 32'd1);

    // R8/R9/R7: break after a data frame
    two_stop = 1'b1;
    s = lidx;
    do_read();
    do_write(9'h0F0);
    brk_req = 1'b1;
    while (zrun < 20) @(negedge clk);
    check("R7", "tidle low in break", {31'd0, tidle}, 32'd0);
    check("R9", "txe in break", {31'd0, txe}, 32'd1);
    check("R9", "irq in break", {31'd0, irq}, 32'd1);
    brk_req = 1'b0;
    cycles(120);
    chk_frame(s, 0, 9'h0F0, 1'b0, 1'b1, "R2", nx);
    z = 0;
    while (nx + z < lidx && !line_log[nx + z]) z++;
    check("R8", "break zero run", z, 32'd28);
    check("R8", "stop after break", {31'd0, line_log[nx + z]}, 32'd1);
    check("R7", "tidle after break", {31'd0, tidle}, 32'd1);
    two_stop = 1'b0;

    // Random words and modes
    for (int k = 0; k < 8; k++) begin
      rd = 9'($urandom);
      nine_bit = 1'($urandom);
      two_stop = 1'($urandom);
      s = lidx;
      do_read();
      do_write(rd);
      check("R3", "txe random", {31'd0, txe}, 32'd1);
      cycles(80);
      chk_frame(s, 0, rd, nine_bit, two_stop, "R2", nx);
      check("R7", "tidle random", {31'd0, tidle}, 32'd1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule